// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel bytes into an asynchronous character stream on a single wire. It runs entirely on one system clock. A one-cycle enable pulse, supplied from outside at sixteen times the wanted bit rate, paces every serial bit. A control register holds the character format: 5 to 8 data bits, odd, even or no parity, and one or two stop bits, where a two-stop request on a 5-bit character yields one and a half stop bits.

A processor places a byte on the write bus and pulses an active-low write strobe. The byte waits in a holding buffer until the shift stage is free, then moves into it and leaves the line as a low start bit, the data bits least significant first, an optional parity bit and the high stop period. Two status pins report whether the holding buffer and the shift stage are empty. The strobe carries no back-pressure of its own: `buf_empty` acts as the ready signal, software writes only while it is high, and a write while it is low replaces the waiting byte.

Top module: `serial_char_tx`

## Requirements
- R1: While `rst` is high, `txd`, `buf_empty` and `shift_empty` are high and every state machine is idle; the control register returns to 8 data bits, no parity, one stop bit; a write strobed right after release is accepted normally.
- R2: Every serial bit of a frame lasts exactly 16 `tick` pulses; without `tick` pulses a frame in progress does not advance.
- R3: A frame is one low start bit, the data bits least significant first, the optional parity bit and the high stop period; the line rests high between frames; `txd` comes from a register.
- R4: `cfg_len` selects 5 (00), 6 (01), 7 (10) or 8 (11) data bits; unused upper bits of `wr_data` are not sent.
- R5: With `cfg_par_off` high no parity bit is sent; otherwise the parity bit makes the count of ones over the active data bits plus parity even when `cfg_par_even` is 1 and odd when it is 0.
- R6: With `cfg_stop2` low the stop period is 16 ticks; high it is 32 ticks, or 24 ticks for 5-bit characters.
- R7: The format inputs are captured on a clock edge where `cfg_load` is high and ignored otherwise; a character keeps the format that was in force when it entered the shift stage.
- R8: `wr_data` is captured on every clock edge where `wr_n` is low; after the first edge that samples `wr_n` high again, `buf_empty` goes low on the following edge.
- R9: `buf_empty` returns high on the edge that moves the byte into the shift stage: one edge after it fell when the shift stage is idle, or at the end of the current stop period otherwise.
- R10: `shift_empty` falls on the transfer edge and rises only when the whole stop period has been sent.
- R11: A byte waiting when a stop period ends starts its start bit at once, with no idle time between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Master reset, active high, asynchronous |
| tick | input | 1 | One-cycle enable at 16x bit rate |
| cfg_load | input | 1 | Capture the format inputs on this edge |
| cfg_len | input | 2 | Data length code |
| cfg_par_off | input | 1 | Suppress the parity bit |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_stop2 | input | 1 | Request the long stop period |
| wr_n | input | 1 | Active-low write strobe; rising edge starts a send |
| wr_data | input | 8 | Byte to send |
| txd | output | 1 | Registered serial output |
| buf_empty | output | 1 | Holding buffer can take a byte |
| shift_empty | output | 1 | Shift stage and line are idle |

## Verification
The strobe path is checked edge by edge: `buf_empty` is expected still high after the first edge that sees `wr_n` high, low after the second, high again after the third with `shift_empty` low, and `txd` low one edge later because the line register sits behind the state machine. Line bits are sampled at the middle of each 48-clock bit, measured from the clock where the start bit first appears, so the sub-tick phase of the first bit cannot move a sample across a boundary. Frame length is taken from start-bit fall to `shift_empty` rise, and the gap between back-to-back frames from start fall to start fall, each compared with a window of one tick period around the tick count the requirements give.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int CHAR_W = 8;
  localparam int LEN_W  = 2;
  localparam int MIN_BITS = CHAR_W - 3;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             par_off;
    logic             par_even;
    logic             stop2;
  } fmt_t;

  localparam fmt_t FMT_RESET = '{len: 2'b11, par_off: 1'b1, par_even: 1'b0, stop2: 1'b0};

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PARITY, S_STOP1, S_STOP2
  } tx_state_t;

  function automatic logic [CHAR_W-1:0] active_mask(input logic [LEN_W-1:0] len);
    logic [CHAR_W-1:0] m;
    for (int i = 0; i < CHAR_W; i++) m[i] = (i < MIN_BITS + int'(len));
    return m;
  endfunction

  function automatic logic parity_of(input logic [CHAR_W-1:0] bits, input logic even);
    return (^bits) ^ ~even;
  endfunction
endpackage

// File: rtl/utx_fmt_reg.sv
module utx_fmt_reg
  import utx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  fmt_t fmt_i,
  output fmt_t fmt_o
);
  fmt_t fmt_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)         fmt_q <= FMT_RESET;
    else if (load_i) fmt_q <= fmt_i;
  end

  assign fmt_o = fmt_q;

  AST_FMT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(fmt_q)); // R7
endmodule

// File: rtl/utx_hold_buf.sv
module utx_hold_buf
  import utx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_n_i,
  input  logic [CHAR_W-1:0] wr_data_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [CHAR_W-1:0] data_o
);
  logic              sync1_q, sync2_q, full_q, rise;
  logic [CHAR_W-1:0] data_q;

  assign rise = sync1_q & ~sync2_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      full_q  <= 1'b0;
    end else begin
      sync1_q <= wr_n_i;
      sync2_q <= sync1_q;
      full_q  <= (full_q & ~take_i) | rise;
    end
  end

  always_ff @(posedge clk) begin
    if (!wr_n_i) data_q <= wr_data_i;
  end

  assign full_o = full_q;
  assign data_o = data_q;

  AST_FULL_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
    rise |=> full_q); // R8
  AST_FULL_WAITS: assert property (@(posedge clk) disable iff (rst)
    (full_q && !take_i) |=> full_q); // R9
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
  import utx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  fmt_t              fmt_i,
  input  logic              full_i,
  input  logic [CHAR_W-1:0] data_i,
  output logic              take_o,
  output logic              txd_o,
  output logic              idle_o
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int IDX_W = $clog2(CHAR_W);
  localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVERSAMPLE / 2 - 1);

  tx_state_t         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [CHAR_W-1:0] sh_q, sh_d;
  logic              par_q, par_d;
  fmt_t              fmt_q, fmt_d;
  logic              take, bit_end, line, txd_q;
  logic [IDX_W-1:0]  last_idx;
  logic [CNT_W-1:0]  stop2_last;
  logic [CHAR_W-1:0] masked;

  assign bit_end    = tick_i && (cnt_q == BIT_LAST);
  assign last_idx   = IDX_W'(MIN_BITS - 1) + IDX_W'(fmt_q.len);
  assign stop2_last = (fmt_q.len == '0) ? HALF_LAST : BIT_LAST;
  assign masked     = data_i & active_mask(fmt_i.len);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    par_d   = par_q;
    fmt_d   = fmt_q;
    take    = 1'b0;
    if (state_q != S_IDLE && tick_i) cnt_d = cnt_q + 1'b1;
    case (state_q)
      S_IDLE:  take = 1'b1;
      S_START: if (bit_end) begin
        state_d = S_DATA;
        cnt_d   = '0;
      end
      S_DATA: if (bit_end) begin
        cnt_d = '0;
        sh_d  = sh_q >> 1;
        idx_d = idx_q + 1'b1;
        if (idx_q == last_idx) begin
          idx_d   = '0;
          state_d = fmt_q.par_off ? S_STOP1 : S_PARITY;
        end
      end
      S_PARITY: if (bit_end) begin
        state_d = S_STOP1;
        cnt_d   = '0;
      end
      S_STOP1: if (bit_end) begin
        cnt_d = '0;
        if (fmt_q.stop2) state_d = S_STOP2;
        else begin
          state_d = S_IDLE;
          take    = 1'b1;
        end
      end
      S_STOP2: if (tick_i && cnt_q == stop2_last) begin
        cnt_d   = '0;
        state_d = S_IDLE;
        take    = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
    if (take && full_i) begin
      state_d = S_START;
      cnt_d   = '0;
      idx_d   = '0;
      sh_d    = masked;
      par_d   = parity_of(masked, fmt_i.par_even);
      fmt_d   = fmt_i;
    end
  end

  always_comb begin
    case (state_q)
      S_START:  line = 1'b0;
      S_DATA:   line = sh_q[0];
      S_PARITY: line = par_q;
      default:  line = 1'b1;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      fmt_q   <= FMT_RESET;
      txd_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      par_q   <= par_d;
      fmt_q   <= fmt_d;
      txd_q   <= line;
    end
  end

  assign take_o = take;
  assign txd_o  = txd_q;
  assign idle_o = (state_q == S_IDLE);

  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_START) |=> !txd_q); // R3
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_STOP1 || state_q == S_STOP2) |=> txd_q); // R6
  AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && state_q != S_IDLE) |=> ($stable(cnt_q) && $stable(state_q))); // R2
  AST_IDLE_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE) |-> (cnt_q == '0)); // R2
endmodule

// File: rtl/serial_char_tx.sv
module serial_char_tx
  import utx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cfg_load,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_par_off,
  input  logic              cfg_par_even,
  input  logic              cfg_stop2,
  input  logic              wr_n,
  input  logic [CHAR_W-1:0] wr_data,
  output logic              txd,
  output logic              buf_empty,
  output logic              shift_empty
);
  fmt_t              fmt_in, fmt_cur;
  logic              full, take;
  logic [CHAR_W-1:0] held;

  assign fmt_in = '{len: cfg_len, par_off: cfg_par_off, par_even: cfg_par_even, stop2: cfg_stop2};

  utx_fmt_reg u_fmt (
    .clk(clk), .rst(rst), .load_i(cfg_load), .fmt_i(fmt_in), .fmt_o(fmt_cur)
  );

  utx_hold_buf u_hold (
    .clk(clk), .rst(rst), .wr_n_i(wr_n), .wr_data_i(wr_data),
    .take_i(take), .full_o(full), .data_o(held)
  );

  utx_shifter #(.OVERSAMPLE(OVERSAMPLE)) u_shift (
    .clk(clk), .rst(rst), .tick_i(tick), .fmt_i(fmt_cur), .full_i(full),
    .data_i(held), .take_o(take), .txd_o(txd), .idle_o(shift_empty)
  );

  assign buf_empty = ~full;

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (shift_empty && $past(shift_empty)) |-> txd); // R3
  AST_EMPTY_THEN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (!buf_empty && shift_empty) |=> (buf_empty && !shift_empty)); // R9
endmodule

// File: tb/serial_char_tx_bench.sv
module serial_char_tx_bench;
  localparam int TD = 3;
  localparam int BC = 16 * TD;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, cfg_load = 1'b0;
  logic [1:0] cfg_len = 2'b11;
  logic cfg_par_off = 1'b1, cfg_par_even = 1'b0, cfg_stop2 = 1'b0;
  logic wr_n = 1'b1;
  logic [7:0] wr_data = 8'h00;
  logic txd, buf_empty, shift_empty;
  int cyc = 0, vectors = 0, miscompares = 0, ta = 0, tb = 0;
  bit finished = 0;

  serial_char_tx u_serial_char_tx (
    .clk(clk), .rst(rst), .tick(tick), .cfg_load(cfg_load), .cfg_len(cfg_len),
    .cfg_par_off(cfg_par_off), .cfg_par_even(cfg_par_even), .cfg_stop2(cfg_stop2),
    .wr_n(wr_n), .wr_data(wr_data), .txd(txd), .buf_empty(buf_empty),
    .shift_empty(shift_empty)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    forever begin
      repeat (TD - 1) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic set_fmt(input logic [1:0] len, input bit poff, input bit even, input bit s2);
    @(negedge clk);
    cfg_len = len; cfg_par_off = poff; cfg_par_even = even; cfg_stop2 = s2; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk);
    wr_data = d; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; wr_data = ~d;
  endtask

  function automatic int frame_ticks(input int len, input bit poff, input bit s2);
    int st = s2 ? ((len == 0) ? 24 : 32) : 16;
    return 16 * (1 + 5 + len + (poff ? 0 : 1)) + st;
  endfunction

  task automatic frame_check(input logic [7:0] d, input int len, input bit poff,
                             input bit even, input string req, output int t0);
    int w = 0;
    int n = 5 + len;
    logic [7:0] m = d & ((8'd1 << n) - 8'd1);
    while (txd !== 1'b0 && w < 4000) begin @(negedge clk); w++; end
    chk(w < 4000, {req, " start bit seen"}, w, 0);
    t0 = cyc;
    for (int i = 0; i < n + (poff ? 0 : 1) + 1; i++) begin
      logic e;
      if (i == 0) e = 1'b0;
      else if (i <= n) e = d[i-1];
      else if (!poff && i == n + 1) e = (^m) ^ ~even;
      else e = 1'b1;
      while (cyc < t0 + i * BC + BC / 2) @(negedge clk);
      chk(txd === e, {req, " line bit"}, int'(txd), int'(e));
    end
  endtask

  task automatic len_check(input int t0, input int ticks, input string req);
    int w = 0;
    while (shift_empty !== 1'b1 && w < 4000) begin @(negedge clk); w++; end
    chk((cyc - t0 >= ticks * TD - 6) && (cyc - t0 <= ticks * TD),
        {req, " frame length"}, cyc - t0, ticks * TD);
  endtask

  task automatic t_reset_state();
    chk(txd === 1'b1, "R1 txd in reset", int'(txd), 1);
    chk(buf_empty === 1'b1, "R1 buf_empty in reset", int'(buf_empty), 1);
    chk(shift_empty === 1'b1, "R1 shift_empty in reset", int'(shift_empty), 1);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_strobe_timing();
    int t0;
    write_byte(8'hA5);
    @(negedge clk);
    chk(buf_empty === 1'b1, "R8 buf_empty after first high sample", int'(buf_empty), 1);
    @(negedge clk);
    chk(buf_empty === 1'b0, "R8 buf_empty falls on second edge", int'(buf_empty), 0);
    @(negedge clk);
    chk(buf_empty === 1'b1, "R9 buf_empty back on transfer", int'(buf_empty), 1);
    chk(shift_empty === 1'b0, "R10 shift_empty falls on transfer", int'(shift_empty), 0);
    chk(txd === 1'b1, "R3 txd register lags state", int'(txd), 1);
    @(negedge clk);
    chk(txd === 1'b0, "R3 start bit one edge after transfer", int'(txd), 0);
    frame_check(8'hA5, 3, 1'b1, 1'b0, "R1 R2 R3 8N1", t0);
    len_check(t0, frame_ticks(3, 1'b1, 1'b0), "R10 R6 8N1");
  endtask

  task automatic t_format(input logic [7:0] d, input logic [1:0] len, input bit poff,
                          input bit even, input bit s2, input string req);
    int t0;
    set_fmt(len, poff, even, s2);
    write_byte(d);
    frame_check(d, int'(len), poff, even, req, t0);
    len_check(t0, frame_ticks(int'(len), poff, s2), req);
  endtask

  task automatic t_fmt_ignore();
    int t0;
    set_fmt(2'b11, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    cfg_len = 2'b00; cfg_par_off = 1'b0; cfg_par_even = 1'b1; cfg_stop2 = 1'b1;
    write_byte(8'h81);
    fork
      frame_check(8'h81, 3, 1'b1, 1'b0, "R7 format held without load", t0);
      begin repeat (150) @(negedge clk); set_fmt(2'b00, 1'b0, 1'b1, 1'b1); end
    join
    len_check(t0, frame_ticks(3, 1'b1, 1'b0), "R7 mid-frame load ignored by frame");
    write_byte(8'h13);
    frame_check(8'h13, 0, 1'b0, 1'b1, "R7 new format on next frame", t0);
    len_check(t0, frame_ticks(0, 1'b0, 1'b1), "R7 R6 new format length");
  endtask

  task automatic t_back_to_back();
    set_fmt(2'b01, 1'b1, 1'b0, 1'b1);
    fork
      begin
        frame_check(8'h2D, 1, 1'b1, 1'b0, "R11 first frame", ta);
        frame_check(8'h12, 1, 1'b1, 1'b0, "R11 second frame", tb);
        @(negedge clk);
        chk(buf_empty === 1'b1, "R9 buf_empty after second transfer", int'(buf_empty), 1);
      end
      begin
        write_byte(8'h2D);
        repeat (3) @(negedge clk);
        write_byte(8'h12);
        repeat (3) @(negedge clk);
        chk(buf_empty === 1'b0, "R9 byte waits while shifting", int'(buf_empty), 0);
      end
    join
    chk((tb - ta >= frame_ticks(1, 1'b1, 1'b1) * TD - 3) && (tb - ta <= frame_ticks(1, 1'b1, 1'b1) * TD + 1),
        "R11 R6 start-to-start gap", tb - ta, frame_ticks(1, 1'b1, 1'b1) * TD);
    len_check(tb, frame_ticks(1, 1'b1, 1'b1), "R11 second frame");
  endtask

  task automatic t_reset_mid();
    int t0;
    set_fmt(2'b10, 1'b0, 1'b0, 1'b0);
    write_byte(8'h00);
    repeat (120) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(txd === 1'b1, "R1 txd high in mid-frame reset", int'(txd), 1);
    chk(buf_empty === 1'b1, "R1 buf_empty in mid-frame reset", int'(buf_empty), 1);
    chk(shift_empty === 1'b1, "R1 shift_empty in mid-frame reset", int'(shift_empty), 1);
    rst = 1'b0;
    write_byte(8'h6E);
    frame_check(8'h6E, 3, 1'b1, 1'b0, "R1 default format after reset", t0);
    len_check(t0, frame_ticks(3, 1'b1, 1'b0), "R1 length after reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    t_strobe_timing();
    t_format(8'h3C, 2'b10, 1'b0, 1'b1, 1'b0, "R4 R5 7E1");
    t_format(8'h2B, 2'b01, 1'b0, 1'b0, 1'b1, "R4 R5 R6 6O2");
    t_format(8'hF5, 2'b00, 1'b0, 1'b1, 1'b1, "R4 R5 R6 5E1.5 upper bits dropped");
    t_format(8'hFE, 2'b00, 1'b0, 1'b0, 1'b0, "R4 R5 5O1");
    t_format(8'h96, 2'b11, 1'b0, 1'b1, 1'b1, "R5 R6 8E2");
    t_fmt_ignore();
    t_back_to_back();
    t_reset_mid();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule